// File: doc/BRIEF.md
# Prioritized Routine Launch Arbiter

This block decides which of seven stored micro-routines is handed to a shared execution engine, and when. Each routine has a start address register. A routine becomes pending when the host requests an immediate start, when an armed event start meets the selected network strobe, or when a per-frame enable is set and that strobe arrives. Routines 0 to 2 are time-critical. Routines 3 to 6 are background work. A critical routine may not be interrupted. A background routine gives way to any pending routine with a lower number, and it later runs again from its start address.

The chosen routine goes to the sequencer on a valid/ready launch channel. `launch_valid` is computed each cycle from the pending set and the running routine. It may drop or change its routine before it is accepted: a newly pending routine can have a lower start address, and a `rt_done` pulse withdraws the offer for that cycle. A launch is committed only in a cycle where both `launch_valid` and `launch_ready` are high. The sequencer pulses `rt_done` for one cycle when the running routine ends. `busy_n` tells the host that routine activity is in progress.

Top module: `routine_launch_arbiter`

## Requirements
- R1: Writing with `cfg_we` high stores `cfg_addr` as the start address of routine `cfg_idx`. A launch of routine i presents that stored address on `launch_addr` and i on `launch_id`.
- R2: A one-cycle pulse on `host_imm_set[i]` for i in 3..6 makes routine i pending. With nothing running, `launch_valid` is high in the cycle after the pulse.
- R3: A pulse on `host_evt_set[i]` (i in 3..6) arms an event start. It launches nothing by itself. When `evt_sel`=1, the armed routine becomes pending on `hdr_pulse` and `fs_pulse` has no effect. When `evt_sel`=0, `fs_pulse` triggers the routine and `hdr_pulse` has no effect.
- R4: An armed event start is cleared when its routine ends (`rt_done`). A later strobe does not launch that routine again.
- R5: While `auto_en[k]` is high, routine 3+k becomes pending on every selected strobe. While `crit_en[i]` is high, routine i (0..2) becomes pending on every selected strobe.
- R6: While routine 0, 1 or 2 is running, `launch_valid` stays low, even if other routines are pending, including critical ones.
- R7: While a routine r in 3..6 is running, only pending routines numbered below r are offered, and `launch_preempt` is high with them. On acceptance the routine r becomes pending again. It is later launched with its original start address.
- R8: Among the eligible pending routines, the one with the lowest start address is offered. Equal addresses go to the lower routine number.
- R9: A launch clears its routine's pending bit and makes it the running routine. When `rt_done` ends the running routine, the next eligible pending routine is offered in the following cycle.
- R10: `busy_n` (active low) is 0 whenever a routine is pending or running. It is 1 otherwise, including after reset.
- R11: Host start pulses on `host_imm_set[2:0]` and `host_evt_set[2:0]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Start address write strobe |
| cfg_idx | input | 3 | Routine whose address is written |
| cfg_addr | input | 7 | Start address value |
| host_imm_set | input | 7 | Host immediate-start pulses, one per routine |
| host_evt_set | input | 7 | Host event-start arming pulses, one per routine |
| crit_en | input | 3 | Per-frame enables of routines 0..2 |
| auto_en | input | 4 | Per-frame auto-start of routines 3..6 |
| evt_sel | input | 1 | 1: header strobe triggers, 0: frame-status strobe triggers |
| hdr_pulse | input | 1 | Header-received strobe |
| fs_pulse | input | 1 | Frame-status-complete strobe |
| rt_done | input | 1 | Running routine finished (one-cycle pulse) |
| launch_valid | output | 1 | A routine is offered for launch |
| launch_ready | input | 1 | Sequencer accepts the offered launch |
| launch_addr | output | 7 | Start address of offered routine |
| launch_id | output | 3 | Number of offered routine |
| launch_preempt | output | 1 | Offered launch interrupts the running routine |
| busy_n | output | 1 | Active-low routine-activity interrupt |

## Verification
A pending bit that is lost or stuck shows within one cycle, as a missing or extra offer on `launch_valid` or as a `busy_n` that releases or stays low at the wrong time. A wrong running-routine record shows on the next strobe or host pulse. It can let a critical routine be interrupted, or it can leave out a required `launch_preempt`. A preempted routine that is not put back as pending shows one cycle after the interrupter's `rt_done`, as a missing relaunch of its start address. An address-table or comparison fault shows in the first cycle that two routines are ready together.

// File: rtl/rla_pkg.sv
package rla_pkg;
  parameter int RT_NUM   = 7;
  parameter int CRIT_NUM = 3;
  parameter int ADDR_W   = 7;
endpackage

// File: rtl/rla_trigger.sv
module rla_trigger #(
  parameter int N  = 7,
  parameter int NC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] host_imm_set,
  input  logic [N-1:0] host_evt_set,
  input  logic [N-1:0] frame_en,
  input  logic         trig,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] set_pend
);
  localparam logic [N-1:0] HOST_OK = {{(N-NC){1'b1}}, {NC{1'b0}}};

  logic [N-1:0] evt_armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_armed_q <= '0;
    else        evt_armed_q <= (evt_armed_q & ~clr_mask) | (host_evt_set & HOST_OK);
  end

  always_comb begin
    set_pend = host_imm_set & HOST_OK;
    if (trig) set_pend = set_pend | evt_armed_q | frame_en;
  end
endmodule

// File: rtl/rla_addr_regs.sv
module rla_addr_regs #(
  parameter int N  = 7,
  parameter int AW = 7,
  localparam int IW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IW-1:0]         cfg_idx,
  input  logic [AW-1:0]         cfg_addr,
  output logic [N-1:0][AW-1:0]  addr_tab
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [AW-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             ent_q <= '0;
      else if (cfg_we && cfg_idx == IW'(g))   ent_q <= cfg_addr;
    end
    assign addr_tab[g] = ent_q;
  end
endmodule

// File: rtl/rla_min_pick.sv
module rla_min_pick #(
  parameter int N  = 7,
  parameter int AW = 7,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]          req,
  input  logic [N-1:0][AW-1:0]  addr_tab,
  output logic                  found,
  output logic [IW-1:0]         sel_id,
  output logic [AW-1:0]         sel_addr
);
  always_comb begin
    found    = 1'b0;
    sel_id   = '0;
    sel_addr = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || addr_tab[i] < sel_addr)) begin
        found    = 1'b1;
        sel_id   = IW'(i);
        sel_addr = addr_tab[i];
      end
    end
  end
endmodule

// File: rtl/routine_launch_arbiter.sv
module routine_launch_arbiter
  import rla_pkg::*;
#(
  parameter int N  = RT_NUM,
  parameter int NC = CRIT_NUM,
  parameter int AW = ADDR_W,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [N-1:0]    host_imm_set,
  input  logic [N-1:0]    host_evt_set,
  input  logic [NC-1:0]   crit_en,
  input  logic [N-NC-1:0] auto_en,
  input  logic            evt_sel,
  input  logic            hdr_pulse,
  input  logic            fs_pulse,
  input  logic            rt_done,
  output logic            launch_valid,
  input  logic            launch_ready,
  output logic [AW-1:0]   launch_addr,
  output logic [IW-1:0]   launch_id,
  output logic            launch_preempt,
  output logic            busy_n
);
  localparam logic [IW-1:0] CRIT_LIM = IW'(NC);
  localparam logic [N-1:0]  ONE      = N'(1);

  logic [N-1:0]          pend_q;
  logic                  run_vld;
  logic [IW-1:0]         run_id;
  logic [N-1:0][AW-1:0]  addr_tab;
  logic [N-1:0]          set_pend, clr_mask, grant_mask, requeue, elig;
  logic                  trig, fin, hs, found;

  assign trig = evt_sel ? hdr_pulse : fs_pulse;
  assign fin  = run_vld && rt_done;

  rla_addr_regs #(.N(N), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .addr_tab(addr_tab)
  );

  rla_trigger #(.N(N), .NC(NC)) u_trig (
    .clk(clk), .rst_n(rst_n), .host_imm_set(host_imm_set),
    .host_evt_set(host_evt_set), .frame_en({auto_en, crit_en}),
    .trig(trig), .clr_mask(clr_mask), .set_pend(set_pend)
  );

  // eligibility: idle -> all pending; critical running -> none;
  // background running -> only lower-numbered routines
  always_comb begin
    elig = '0;
    if (!run_vld) begin
      elig = pend_q;
    end else if (run_id >= CRIT_LIM && !rt_done) begin
      for (int j = 0; j < N; j++) elig[j] = pend_q[j] && (IW'(j) < run_id);
    end
  end

  rla_min_pick #(.N(N), .AW(AW)) u_pick (
    .req(elig), .addr_tab(addr_tab), .found(found),
    .sel_id(launch_id), .sel_addr(launch_addr)
  );

  assign launch_valid   = found;
  assign launch_preempt = found && run_vld;
  assign hs             = launch_valid && launch_ready;
  assign clr_mask       = fin ? (ONE << run_id) : '0;
  assign grant_mask     = hs ? (ONE << launch_id) : '0;
  assign requeue        = (hs && run_vld) ? (ONE << run_id) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      run_vld <= 1'b0;
      run_id  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant_mask) | set_pend | requeue;
      if (hs) begin
        run_vld <= 1'b1;
        run_id  <= launch_id;
      end else if (fin) begin
        run_vld <= 1'b0;
      end
    end
  end

  assign busy_n = !(run_vld || (|pend_q));
endmodule

// File: rtl/rla_checker.sv
module rla_checker #(
  parameter int N  = 7,
  parameter int NC = 3,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          launch_valid,
  input logic          launch_ready,
  input logic [IW-1:0] launch_id,
  input logic          busy_n,
  input logic          rt_done,
  input logic          run_vld,
  input logic [IW-1:0] run_id
);
  localparam logic [IW-1:0] CRIT_LIM = IW'(NC);

  AST_CRIT_NO_INTERRUPT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld && run_id < CRIT_LIM) |-> !launch_valid); // R6
  AST_PREEMPT_LOWER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && run_vld) |-> (launch_id < run_id)); // R7
  AST_GRANT_BECOMES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && launch_ready) |=> (run_vld && run_id == $past(launch_id))); // R9
  AST_NO_OFFER_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld && rt_done) |-> !launch_valid); // R9
  AST_BUSY_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_vld || launch_valid) |-> !busy_n); // R10
endmodule

bind routine_launch_arbiter rla_checker #(.N(N), .NC(NC)) i_chk (
  .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
  .launch_ready(launch_ready), .launch_id(launch_id), .busy_n(busy_n),
  .rt_done(rt_done), .run_vld(run_vld), .run_id(run_id)
);

// File: tb/test_routine_launch_arbiter.sv
module test_routine_launch_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [6:0] cfg_addr = '0;
  logic [6:0] host_imm_set = '0, host_evt_set = '0;
  logic [2:0] crit_en = '0;
  logic [3:0] auto_en = '0;
  logic       evt_sel = 1'b1, hdr_pulse = 1'b0, fs_pulse = 1'b0, rt_done = 1'b0;
  logic       launch_ready = 1'b0;
  logic       launch_valid, launch_preempt, busy_n;
  logic [6:0] launch_addr;
  logic [2:0] launch_id;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  routine_launch_arbiter i_routine_launch_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_addr(cfg_addr), .host_imm_set(host_imm_set),
    .host_evt_set(host_evt_set), .crit_en(crit_en), .auto_en(auto_en),
    .evt_sel(evt_sel), .hdr_pulse(hdr_pulse), .fs_pulse(fs_pulse),
    .rt_done(rt_done), .launch_valid(launch_valid),
    .launch_ready(launch_ready), .launch_addr(launch_addr),
    .launch_id(launch_id), .launch_preempt(launch_preempt), .busy_n(busy_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_none(input string req);
    chk(launch_valid == 1'b0, req, launch_valid, 0);
  endtask

  task automatic chk_offer(input string req, input int id, input int addr, input bit pre);
    chk(launch_valid === 1'b1, req, launch_valid, 1);
    chk(launch_id == id, req, launch_id, id);
    chk(launch_addr == addr, req, launch_addr, addr);
    chk(launch_preempt == pre, req, launch_preempt, pre);
  endtask

  task automatic wr_addr(input int idx, input int a);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_addr = 7'(a);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic accept();
    launch_ready = 1'b1; step(); launch_ready = 1'b0;
  endtask

  task automatic finish_rt();
    rt_done = 1'b1; step(); rt_done = 1'b0;
  endtask

  task automatic imm(input logic [6:0] m);
    host_imm_set = m; step(); host_imm_set = '0;
  endtask

  task automatic hdr();
    hdr_pulse = 1'b1; step(); hdr_pulse = 1'b0;
  endtask

  task automatic fs();
    fs_pulse = 1'b1; step(); fs_pulse = 1'b0;
  endtask

  task automatic t_reset();
    chk_none("R10 reset valid");
    chk(busy_n == 1'b1, "R10 reset busy_n", busy_n, 1);
  endtask

  task automatic t_immediate();
    imm(7'b0010000);
    chk_offer("R2 R1 imm routine4", 4, 'h30, 0);
    chk(busy_n == 1'b0, "R10 busy while pending", busy_n, 0);
    accept();
    chk_none("R9 pending cleared by launch");
    chk(busy_n == 1'b0, "R10 busy while running", busy_n, 0);
    finish_rt();
    chk(busy_n == 1'b1, "R10 busy released", busy_n, 1);
  endtask

  task automatic t_order();
    imm(7'b0101000);
    chk_offer("R8 lowest address r3", 3, 'h08, 0);
    accept();
    chk_none("R7 higher number does not preempt");
    finish_rt();
    chk_offer("R9 next after done", 5, 'h50, 0);
    accept(); finish_rt();
    wr_addr(6, 'h04);
    imm(7'b1010000);
    chk_offer("R8 address beats number", 6, 'h04, 0);
    accept();
    chk_offer("R7 lower number preempts r6", 4, 'h30, 1);
    accept();
    chk_none("R7 interrupter runs");
    finish_rt();
    chk_offer("R7 r6 restarts at start address", 6, 'h04, 0);
    accept(); finish_rt();
    wr_addr(6, 'h60);
    wr_addr(5, 'h30);
    imm(7'b0110000);
    chk_offer("R8 equal address lower number", 4, 'h30, 0);
    accept(); finish_rt();
    chk_offer("R8 tie remainder", 5, 'h30, 0);
    accept(); finish_rt();
    wr_addr(5, 'h50);
  endtask

  task automatic t_host_crit_ignored();
    imm(7'b0000111);
    host_evt_set = 7'b0000111; step(); host_evt_set = '0;
    step();
    chk_none("R11 host crit imm ignored");
    hdr();
    chk_none("R11 host crit evt ignored");
    chk(busy_n == 1'b1, "R11 busy stays idle", busy_n, 1);
  endtask

  task automatic t_events();
    evt_sel = 1'b1;
    host_evt_set = 7'b0100000; step(); host_evt_set = '0;
    chk_none("R3 arming alone no launch");
    fs();
    chk_none("R3 fs ignored when sel=1");
    hdr();
    chk_offer("R3 hdr launches r5", 5, 'h50, 0);
    accept(); finish_rt();
    hdr();
    chk_none("R4 armed bit cleared on done");
    evt_sel = 1'b0;
    host_evt_set = 7'b0010000; step(); host_evt_set = '0;
    hdr();
    chk_none("R3 hdr ignored when sel=0");
    fs();
    chk_offer("R3 fs launches r4", 4, 'h30, 0);
    accept(); finish_rt();
    evt_sel = 1'b1;
  endtask

  task automatic t_auto();
    auto_en = 4'b0100;
    for (int f = 0; f < 2; f++) begin
      hdr();
      chk_offer("R5 auto start each frame", 5, 'h50, 0);
      accept(); finish_rt();
    end
    auto_en = '0;
    crit_en = 3'b010;
    hdr();
    chk_offer("R5 crit enable frame start", 1, 'h10, 0);
    crit_en = '0;
    accept(); finish_rt();
  endtask

  task automatic t_preempt();
    imm(7'b0100000);
    accept();
    crit_en = 3'b001; hdr(); crit_en = '0;
    chk_offer("R7 critical preempts r5", 0, 'h40, 1);
    accept();
    chk_none("R6 critical running");
    finish_rt();
    chk_offer("R7 r5 restarts", 5, 'h50, 0);
    accept(); finish_rt();
    chk(busy_n == 1'b1, "R10 idle after preempt", busy_n, 1);
  endtask

  task automatic t_crit_hold();
    crit_en = 3'b100; hdr(); crit_en = '0;
    chk_offer("R5 r2 frame start", 2, 'h20, 0);
    accept();
    crit_en = 3'b001; hdr(); crit_en = '0;
    chk_none("R6 no interrupt by critical");
    imm(7'b0001000);
    chk_none("R6 no start of background");
    finish_rt();
    chk_offer("R8 r3 before r0 by address", 3, 'h08, 0);
    accept();
    chk_offer("R7 r0 preempts r3", 0, 'h40, 1);
    accept(); finish_rt();
    chk_offer("R7 r3 restarts", 3, 'h08, 0);
    accept(); finish_rt();
    chk(busy_n == 1'b1, "R10 idle at end", busy_n, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    wr_addr(0, 'h40); wr_addr(1, 'h10); wr_addr(2, 'h20); wr_addr(3, 'h08);
    wr_addr(4, 'h30); wr_addr(5, 'h50); wr_addr(6, 'h60);
    wr_addr(7, 'h01);
    t_immediate();
    t_order();
    t_host_crit_ignored();
    t_events();
    t_auto();
    t_preempt();
    t_crit_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule